// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Output

This block drives one or more output pins. Each pin carries a divided clock or a buzzer tone. Every channel has its own 8-bit select register, which software writes through a single-cycle write port and reads back through a combinational read port. A register holds three things: an output-enable bit, a source-select bit that picks one of two clock-enable strobes, and a three-bit ratio field. The ratio field sets the division power of two.

Each channel runs a divider from the strobe it has selected. The divider produces a square wave with a 50% duty cycle. A gate lets that wave through to the pin. The gate and the active ratio change only at the point where the divided wave goes low. As a result, a pin starts and stops on whole-period boundaries, and a high pulse never comes out truncated. Changes to the ratio or source while a channel runs also wait for that low point.

Top module: `clk_tone_out`

## Requirements
- R1: After reset, every select register reads 0x00 and every pin is low.
- R2: A write stores data bits 7 (enable), 3 (source) and 2..0 (ratio field k) into the addressed channel's register. Bits 6..4 are not stored and always read back as 0.
- R3: While a channel's enable bit is 0 and its previous output has finished, its pin stays low.
- R4: With the channel enabled, the pin is high for 2^k strobes and then low for 2^k strobes of the selected source. Source bit 0 picks src_tick[0] and source bit 1 picks src_tick[1].
- R5: Setting the enable takes effect at the next falling point of the divided wave. The pin first rises only after a full low phase, and its first high pulse has full width. Clearing the enable lets the current high pulse finish at full width, and the pin then stays low.
- R6: A new ratio written while the channel runs takes effect at the next falling point. No high pulse is shorter than the half period of the smaller ratio, and later pulses use the new ratio.
- R7: Channels are independent. A write to one channel changes neither the register contents nor the pin waveform of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | CH_W | Channel addressed by a write |
| wr_data | input | 8 | Write data |
| rd_chan | input | CH_W | Channel whose register is read |
| rd_data | output | 8 | Read-back value of the selected register |
| src_tick | input | 2 | Clock-enable strobes of the two sources |
| pin_out | output | NCH | Gated divided clock, one bit per channel |

## Verification
The bench builds the block with its default of two channels. Source 0 is strobed every clock and source 1 every third clock. With ratio fields from 0 to 7, this brings both sources, the full ratio range and two channels running at the same time within reach. Widths come out as exact clock counts, so a one-strobe shift at enable, disable or a ratio change shows up as a wrong pulse width.

// File: rtl/clk_tone_pkg.sv
package clk_tone_pkg;
  localparam int FLD_W = 3;
  localparam int CNT_W = 1 << FLD_W;

  typedef struct packed {
    logic             en;
    logic [2:0]       rsv;
    logic             src;
    logic [FLD_W-1:0] k;
  } sel_reg_t;

  function automatic logic [CNT_W-1:0] half_count(input logic [FLD_W-1:0] k);
    half_count = CNT_W'(1) << k;
  endfunction

  function automatic logic [7:0] clean_reg(input logic [7:0] d);
    clean_reg = d & 8'h8F;
  endfunction
endpackage

// File: rtl/tone_regs.sv
module tone_regs
  import clk_tone_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int CH_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_chan,
  input  logic [7:0]      wr_data,
  input  logic [CH_W-1:0] rd_chan,
  output logic [7:0]      rd_data,
  output sel_reg_t        cfg [NCH]
);
  logic [7:0] regs_q [NCH];

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[gi] <= 8'h00;
        else if (wr_en && (int'(wr_chan) == gi)) regs_q[gi] <= clean_reg(wr_data);
      end
      assign cfg[gi] = sel_reg_t'(regs_q[gi]);
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NCH; i++)
      if (int'(rd_chan) == i) rd_data = regs_q[i];
  end

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:4] == 3'b000);
endmodule

// File: rtl/tone_div.sv
module tone_div
  import clk_tone_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_src,
  input  logic [FLD_W-1:0] cfg_k,
  input  logic [1:0]       src_tick,
  output logic             pin_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic             gate_q;
  logic [FLD_W-1:0] k_act;
  logic             src_act;

  logic tick;
  logic wrap_evt;
  logic fall_evt;
  logic rise_evt;

  assign tick     = src_act ? src_tick[1] : src_tick[0];
  assign wrap_evt = tick && (cnt_q >= half_count(k_act) - CNT_W'(1));
  assign fall_evt = wrap_evt && phase_q;
  assign rise_evt = wrap_evt && !phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      gate_q  <= 1'b0;
      k_act   <= '0;
      src_act <= 1'b0;
    end else begin
      if (tick) begin
        if (wrap_evt) begin
          cnt_q   <= '0;
          phase_q <= ~phase_q;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
      if (fall_evt) gate_q <= cfg_en;
      if (fall_evt || !gate_q) begin
        k_act   <= cfg_k;
        src_act <= cfg_src;
      end
    end
  end

  assign pin_o = phase_q & gate_q;

  p_gate_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_q) |-> !phase_q);

  p_ratio_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(k_act) && $past(gate_q)) |-> !phase_q);

  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg_en) && $past(!gate_q)) |-> !pin_o);

  p_edge_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_q) |-> $past(tick));

  p_rise_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_o) |-> $past(rise_evt));
endmodule

// File: rtl/clk_tone_out.sv
module clk_tone_out
  import clk_tone_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_chan,
  input  logic [7:0]      wr_data,
  input  logic [CH_W-1:0] rd_chan,
  output logic [7:0]      rd_data,
  input  logic [1:0]      src_tick,
  output logic [NCH-1:0]  pin_out
);
  sel_reg_t cfg [NCH];

  tone_regs #(.NCH(NCH), .CH_W(CH_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_chan (wr_chan),
    .wr_data (wr_data),
    .rd_chan (rd_chan),
    .rd_data (rd_data),
    .cfg     (cfg)
  );

  genvar gc;
  generate
    for (gc = 0; gc < NCH; gc++) begin : g_ch
      tone_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg[gc].en),
        .cfg_src  (cfg[gc].src),
        .cfg_k    (cfg[gc].k),
        .src_tick (src_tick),
        .pin_o    (pin_out[gc])
      );
    end
  endgenerate
endmodule

// File: tb/clk_tone_out_test.sv
`timescale 1ns/1ps
module clk_tone_out_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] wr_chan = '0;
  logic [7:0] wr_data = '0;
  logic [0:0] rd_chan = '0;
  logic [7:0] rd_data;
  logic [1:0] src_tick = 2'b01;
  logic [1:0] pin_out;

  int n_chk = 0;
  int n_err = 0;
  int div3 = 0;
  int run_hi [2];
  int last_hi [2];
  int min_hi [2];

  always #4 clk = ~clk;

  clk_tone_out uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_data(wr_data), .rd_chan(rd_chan), .rd_data(rd_data),
    .src_tick(src_tick), .pin_out(pin_out)
  );

  // source 1 strobes every third clock
  always @(negedge clk) begin
    div3 = (div3 == 2) ? 0 : div3 + 1;
    src_tick[1] <= (div3 == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // runt monitor on high pulses (R5, R6)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (pin_out[c]) run_hi[c]++;
        else begin
          if (run_hi[c] != 0) begin
            last_hi[c] = run_hi[c];
            if (min_hi[c] > 0) chk(run_hi[c] >= min_hi[c], "R6 runt high pulse", run_hi[c], min_hi[c]);
          end
          run_hi[c] = 0;
        end
      end
    end
  end

  task automatic wr(input int ch, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = 1'(ch); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, output logic [7:0] d);
    @(negedge clk);
    rd_chan = 1'(ch);
    #1 d = rd_data;
  endtask

  // waits for a rising pin edge; returns cycles waited
  task automatic wait_rise(input int ch, output int waited);
    logic prev;
    waited = 0;
    @(negedge clk);
    prev = pin_out[ch];
    forever begin
      @(negedge clk);
      waited++;
      if (pin_out[ch] && !prev) break;
      prev = pin_out[ch];
      if (waited > 5000) break;
    end
  endtask

  task automatic measure(input int ch, output int hi, output int lo);
    hi = 1; lo = 0;
    while (1) begin @(negedge clk); if (!pin_out[ch]) break; hi++; end
    lo = 1;
    while (1) begin @(negedge clk); if (pin_out[ch]) break; lo++; if (lo > 5000) break; end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int c = 0; c < 2; c++) begin
      rd(c, d);
      chk(d == 8'h00, "R1 reset register", d, 0);
    end
    repeat (20) begin
      @(negedge clk);
      chk(pin_out == 2'b00, "R1 pins low after reset", pin_out, 0);
    end
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(0, 8'hFF);
    rd(0, d); chk(d == 8'h8F, "R2 readback reserved zero", d, 8'h8F);
    rd(1, d); chk(d == 8'h00, "R7 other channel untouched", d, 0);
    wr(0, 8'h7A);
    rd(0, d); chk(d == 8'h0A, "R2 readback masked", d, 8'h0A);
    wr(1, 8'h0D);
    rd(1, d); chk(d == 8'h0D, "R2 ch1 readback", d, 8'h0D);
    rd(0, d); chk(d == 8'h0A, "R7 ch0 kept", d, 8'h0A);
    wr(0, 8'h00); wr(1, 8'h00);
    repeat (300) @(negedge clk);
    repeat (20) begin
      @(negedge clk);
      chk(pin_out == 2'b00, "R3 disabled pins low", pin_out, 0);
    end
  endtask

  task automatic t_freq(input int ch, input int k, input int src);
    int half, w, hi, lo;
    half = (1 << k) * (src ? 3 : 1);
    min_hi[ch] = half;
    wr(ch, 8'(8'h80 | (src << 3) | k));
    wait_rise(ch, w);
    chk(w >= half, "R5 full low phase before first rise", w, half);
    measure(ch, hi, lo);
    chk(hi == half, "R5 first high full width", hi, half);
    chk(lo == half, "R4 low width", lo, half);
    measure(ch, hi, lo);
    chk(hi == half, "R4 high width", hi, half);
    chk(lo == half, "R4 second low width", lo, half);
    wr(ch, 8'h00);
    repeat (2 * half + 4) @(negedge clk);
    repeat (10) begin
      @(negedge clk);
      chk(pin_out[ch] == 1'b0, "R3 low after disable", pin_out[ch], 0);
    end
    min_hi[ch] = 0;
  endtask

  task automatic t_disable;
    int w;
    min_hi[0] = 4;
    wr(0, 8'h82);
    wait_rise(0, w);
    wr(0, 8'h02);
    repeat (20) @(negedge clk);
    chk(last_hi[0] == 4, "R5 last high full width", last_hi[0], 4);
    repeat (30) begin
      @(negedge clk);
      chk(pin_out[0] == 1'b0, "R5 stays low after disable", pin_out[0], 0);
    end
    min_hi[0] = 0;
  endtask

  task automatic t_ratio;
    int w, hi, lo;
    min_hi[0] = 2;
    wr(0, 8'h81);
    wait_rise(0, w);
    wr(0, 8'h83);
    wait_rise(0, w);
    wait_rise(0, w);
    measure(0, hi, lo);
    chk(hi == 8, "R6 new ratio high", hi, 8);
    chk(lo == 8, "R6 new ratio low", lo, 8);
    wr(0, 8'h00);
    repeat (40) @(negedge clk);
    min_hi[0] = 0;
  endtask

  task automatic t_indep;
    int w, hi, lo;
    logic [7:0] d;
    min_hi[1] = 12;
    wr(1, 8'h8A);
    wait_rise(1, w);
    fork
      begin
        wr(0, 8'h81); wr(0, 8'h07); wr(0, 8'h8C); wr(0, 8'h00);
      end
      begin
        measure(1, hi, lo);
        chk(hi == 12 && lo == 12, "R7 ch1 unaffected width", hi, 12);
      end
    join
    rd(1, d);
    chk(d == 8'h8A, "R7 ch1 register kept", d, 8'h8A);
    wr(1, 8'h00);
    repeat (60) @(negedge clk);
    min_hi[1] = 0;
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin run_hi[c] = 0; last_hi[c] = 0; min_hi[c] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_freq(0, 0, 0);
    t_freq(0, 2, 0);
    t_freq(0, 1, 1);
    t_freq(1, 3, 0);
    t_freq(1, 7, 0);
    t_freq(1, 2, 1);
    t_disable();
    t_ratio();
    t_indep();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule